// File: doc/BRIEF.md
# Receive FIFO Fill-Level and Idle Monitor

This block sits beside the receive FIFO of a serial port and derives every fill-dependent control from the FIFO's occupancy count. A single 2-bit level select picks one threshold. That threshold drives three outputs:

- the data-available flag used by the interrupt logic;
- the active-low DMA receive request;
- the point at which the active-low ready-to-send line is deasserted in automatic flow control.

An idle timer runs in parallel with the threshold logic. It counts character-time ticks from the baud generator. It raises a character-timeout flag when data has sat in the FIFO for four character times with nothing written or read.

The FIFO storage is not part of the block. The block reads only the count, the push and pop strobes, the level select, the FIFO-enable and flow-control-enable settings, and the tick. When the FIFO is disabled, the port behaves as a single holding register, so the effective depth is one.

Top module: `rx_fill_monitor`

## Requirements
- R1: With FIFOs enabled and level select 2'b00, the threshold is 1 entry.
- R2: With FIFOs enabled and level select 2'b01, the threshold is DEPTH/4 entries (4 for DEPTH=16).
- R3: With FIFOs enabled and level select 2'b10, the threshold is DEPTH/2 entries (8 for DEPTH=16).
- R4: With FIFOs enabled and level select 2'b11, the threshold is DEPTH-2 entries (14 for DEPTH=16).
- R5: With FIFOs disabled (fifo_en=0), the threshold is 1 entry for every level select.
- R6: lvl_hit is high exactly while fifo_count >= threshold. It follows the count in the same cycle, with no register in the path.
- R7: dma_rx_req_n is low exactly when lvl_hit is high, in the same cycle.
- R8: With afc_en=1, rts_n goes high on the clock edge where fifo_count >= threshold. It stays high while the count lies between 1 and threshold-1. It goes low on the edge where fifo_count is 0.
- R9: With afc_en=0, rts_n is low from the next clock edge on.
- R10: If fifo_count is non-zero and no push or pop occurs, char_timeout rises on the edge of the fourth char_tick.
- R11: A push or pop clears char_timeout on that edge and restarts the count of four ticks.
- R12: While fifo_count is 0, ticks are not counted and char_timeout stays low.
- R13: After reset, rts_n and char_timeout are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled (0 gives an effective depth of 1) |
| afc_en | input | 1 | Automatic flow control enable |
| lvl_sel | input | 2 | Receive level select |
| fifo_count | input | $clog2(DEPTH+1) | Current receive FIFO occupancy |
| push | input | 1 | A character was written into the FIFO this cycle |
| pop | input | 1 | A character was read from the FIFO this cycle |
| char_tick | input | 1 | One-cycle pulse per character time |
| lvl_hit | output | 1 | Occupancy at or above threshold |
| dma_rx_req_n | output | 1 | Active-low DMA receive request |
| rts_n | output | 1 | Active-low ready-to-send |
| char_timeout | output | 1 | Character timeout flag |

## Verification
The outputs do not all respond with the same delay:

- lvl_hit and dma_rx_req_n are combinational, so the bench samples them at the falling edge of the same cycle in which the count is driven.
- rts_n and char_timeout each pass through one register. The bench drives a stimulus at a falling edge and checks these outputs at the next falling edge, after the single capturing rising edge.

The threshold sweep covers every count from 0 to DEPTH for each level select and both FIFO-enable settings, and compares against a threshold the bench computes itself. The timeout checks count ticks one by one, so the flag is examined both after the third tick and after the fourth.

// File: rtl/rxmon_pkg.sv
package rxmon_pkg;

  // Threshold in entries for a level select; disabled FIFO acts as depth 1.
  function automatic int unsigned level_threshold(input logic en,
                                                  input logic [1:0] sel,
                                                  input int unsigned depth);
    int unsigned t;
    if (!en) return 1;
    case (sel)
      2'b00:   t = 1;
      2'b01:   t = depth / 4;
      2'b10:   t = depth / 2;
      default: t = depth - 2;
    endcase
    if (t == 0) t = 1;
    return t;
  endfunction

endpackage

// File: rtl/rxmon_level.sv
module rxmon_level
  import rxmon_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             fifo_en,
  input  logic [1:0]       lvl_sel,
  input  logic [CNT_W-1:0] fifo_count,
  output logic [CNT_W-1:0] thr,
  output logic             at_level
);

  assign thr      = CNT_W'(level_threshold(fifo_en, lvl_sel, DEPTH));
  assign at_level = (fifo_count >= thr);

  // R6: a threshold is never zero, so the flag implies data present
  always_comb
    assert_level_nonempty_R6: assert (!at_level || fifo_count != '0);

endmodule

// File: rtl/rxmon_rts.sv
module rxmon_rts #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             afc_en,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             at_level,
  output logic             rts_n
);

  logic fifo_empty;
  assign fifo_empty = (fifo_count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rts_n <= 1'b0;
    else if (!afc_en)    rts_n <= 1'b0;
    else if (fifo_empty) rts_n <= 1'b0;
    else if (at_level)   rts_n <= 1'b1;
  end

  assert_rts_empty_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |=> !rts_n);
  assert_rts_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_n) |-> $past(at_level && afc_en));
  assert_rts_afc_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !afc_en |=> !rts_n);

endmodule

// File: rtl/rxmon_idle.sv
module rxmon_idle #(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned IDLE_CHARS = 4,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned IDLE_W = $clog2(IDLE_CHARS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             push,
  input  logic             pop,
  input  logic             char_tick,
  output logic             timed_out
);

  localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(IDLE_CHARS);

  logic [IDLE_W-1:0] idle_cnt;
  logic              activity;
  logic              fifo_empty;

  assign activity   = push | pop;
  assign fifo_empty = (fifo_count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               idle_cnt <= '0;
    else if (activity || fifo_empty)          idle_cnt <= '0;
    else if (char_tick && idle_cnt != IDLE_LIM) idle_cnt <= idle_cnt + 1'b1;
  end

  assign timed_out = (idle_cnt == IDLE_LIM);

  assert_idle_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= IDLE_LIM);
  assert_activity_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !timed_out);
  assert_empty_no_timeout_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |=> !timed_out);

endmodule

// File: rtl/rx_fill_monitor.sv
module rx_fill_monitor #(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned IDLE_CHARS = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             afc_en,
  input  logic [1:0]       lvl_sel,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             push,
  input  logic             pop,
  input  logic             char_tick,
  output logic             lvl_hit,
  output logic             dma_rx_req_n,
  output logic             rts_n,
  output logic             char_timeout
);

  logic [CNT_W-1:0] thr;
  logic             at_level;

  rxmon_level #(.DEPTH(DEPTH)) u_level (
    .fifo_en    (fifo_en),
    .lvl_sel    (lvl_sel),
    .fifo_count (fifo_count),
    .thr        (thr),
    .at_level   (at_level)
  );

  rxmon_rts #(.DEPTH(DEPTH)) u_rts (
    .clk        (clk),
    .rst_n      (rst_n),
    .afc_en     (afc_en),
    .fifo_count (fifo_count),
    .at_level   (at_level),
    .rts_n      (rts_n)
  );

  rxmon_idle #(.DEPTH(DEPTH), .IDLE_CHARS(IDLE_CHARS)) u_idle (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_count (fifo_count),
    .push       (push),
    .pop        (pop),
    .char_tick  (char_tick),
    .timed_out  (char_timeout)
  );

  assign lvl_hit      = at_level;
  assign dma_rx_req_n = ~at_level;

  // R7: a DMA request only ever asks for data that exists
  always_comb
    assert_dma_nonempty_R7: assert (dma_rx_req_n || fifo_count != '0);
  // R5: disabled FIFO means any single character reaches the level
  always_comb
    assert_disabled_thr_R5: assert (fifo_en || thr == CNT_W'(1));
  // R10: a timeout is only reported for data that was waiting
  assert_timeout_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    char_timeout |-> $past(fifo_count != '0));

endmodule

// File: tb/rx_fill_monitor_bench.sv
module rx_fill_monitor_bench;

  localparam int unsigned DEPTH = 16;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0, afc_en = 1'b0;
  logic [1:0] lvl_sel = 2'b00;
  logic [CNT_W-1:0] fifo_count = '0;
  logic push = 1'b0, pop = 1'b0, char_tick = 1'b0;
  logic lvl_hit, dma_rx_req_n, rts_n, char_timeout;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rx_fill_monitor #(.DEPTH(DEPTH), .IDLE_CHARS(4)) u_rx_fill_monitor (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .afc_en(afc_en),
    .lvl_sel(lvl_sel), .fifo_count(fifo_count), .push(push), .pop(pop),
    .char_tick(char_tick), .lvl_hit(lvl_hit), .dma_rx_req_n(dma_rx_req_n),
    .rts_n(rts_n), .char_timeout(char_timeout)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_thr(input bit en, input int sel);
    if (!en) return 1;
    if (sel == 0) return 1;
    if (sel == 1) return DEPTH >> 2;
    if (sel == 2) return DEPTH >> 1;
    return DEPTH - 2;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      char_tick = 1'b1; step();
      char_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R13: reset state
    repeat (3) step();
    chk("R13 rts_n in reset", rts_n, 0);
    chk("R13 timeout in reset", char_timeout, 0);
    rst_n = 1'b1;
    step();
    chk("R13 rts_n after reset", rts_n, 0);
    chk("R13 timeout after reset", char_timeout, 0);

    // R1-style sweep: R1 R2 R3 R4 R5 R6 R7 over all counts
    for (int en = 0; en < 2; en++) begin
      for (int s = 0; s < 4; s++) begin
        for (int c = 0; c <= DEPTH; c++) begin
          fifo_en = en[0]; lvl_sel = s[1:0]; fifo_count = CNT_W'(c);
          #1;
          begin
            int e;
            string tag;
            e = (c >= exp_thr(en[0], s)) ? 1 : 0;
            tag = !en[0] ? "R5" : (s == 0) ? "R1" : (s == 1) ? "R2" : (s == 2) ? "R3" : "R4";
            chk({tag, " R6 lvl_hit"}, lvl_hit, e);
            chk({tag, " R7 dma_rx_req_n"}, dma_rx_req_n, 1 - e);
          end
        end
      end
    end
    step();

    // R8: flow control with hysteresis, level select 01 -> threshold 4
    fifo_en = 1'b1; lvl_sel = 2'b01; afc_en = 1'b1;
    fifo_count = 3; step();
    chk("R8 below level", rts_n, 0);
    fifo_count = 4; step();
    chk("R8 at level", rts_n, 1);
    fifo_count = 2; step();
    chk("R8 hold above empty", rts_n, 1);
    fifo_count = 1; step();
    chk("R8 hold at one", rts_n, 1);
    fifo_count = 0; step();
    chk("R8 empty", rts_n, 0);
    fifo_count = 3; step();
    chk("R8 refill below level", rts_n, 0);
    lvl_sel = 2'b11; fifo_count = 14; step();
    chk("R8 R4 at 14", rts_n, 1);
    // R9: flow control off
    afc_en = 1'b0; step();
    chk("R9 afc off", rts_n, 0);
    fifo_count = 16; step();
    chk("R9 full with afc off", rts_n, 0);

    // R10: timeout after exactly four ticks
    fifo_count = 3; step();
    tick_n(3);
    chk("R10 after 3 ticks", char_timeout, 0);
    tick_n(1);
    chk("R10 after 4 ticks", char_timeout, 1);
    step();
    chk("R10 holds", char_timeout, 1);
    // R11: pop clears
    pop = 1'b1; step(); pop = 1'b0;
    chk("R11 pop clears", char_timeout, 0);
    tick_n(2);
    push = 1'b1; step(); push = 1'b0;
    tick_n(3);
    chk("R11 push restarts", char_timeout, 0);
    tick_n(1);
    chk("R11 fourth tick after push", char_timeout, 1);
    push = 1'b1; step(); push = 1'b0;
    chk("R11 push clears", char_timeout, 0);
    // R12: empty FIFO never times out
    fifo_count = 0; step();
    tick_n(6);
    chk("R12 empty after 6 ticks", char_timeout, 0);
    fifo_count = 1;
    tick_n(4);
    chk("R12 count resumes from zero", char_timeout, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule